// File: doc/BRIEF.md
# Generalized Parallel Counter Library

This block is a purely combinational counter that adds bits spread over up to four neighbouring columns of increasing weight. It returns their weighted total as a short unsigned binary number. A counter type is written as (c3,c2,c1,c0;m), where ci is the number of input bits of weight 2^i and m is the output width. Unlike a single-column (3;2) full adder, these counters take irregular column shapes, and some columns may be empty. Such counters are the building cells of compressor trees for multi-operand addition and multiplication.

One top-level wrapper holds the six counter shapes. A parameter picks the shape, and the input and output widths follow from it. Inside, each populated column is counted on its own. The column counts are then shifted by their weights and added. The result is exact for every input pattern, so the output always equals the weighted sum of the set input bits.

Top module: `gpc_counter`

## Requirements
- R1: The parameter `KIND` picks the counter shape. `bits_in` packs the bits column by column, from weight 1 upward: the weight-1 bits take the lowest indices, the bits of the next populated weight follow directly above them, and so on. Empty columns take no positions.
- R2: With `KIND = GPC_1_5` (value 0) the counter takes 5 bits of weight 1 in `bits_in[4:0]` and 1 bit of weight 2 in `bits_in[5]`. `sum_out` is 3 bits wide.
- R3: With `KIND = GPC_6` (value 1) the counter takes 6 bits of weight 1 in `bits_in[5:0]`. `sum_out` is 3 bits wide.
- R4: With `KIND = GPC_1_4_1_5` (value 2) the counter takes 5, 1, 4 and 1 bits of weight 1, 2, 4 and 8 in `bits_in[4:0]`, `[5]`, `[9:6]` and `[10]`. `sum_out` is 5 bits wide.
- R5: With `KIND = GPC_1_4_0_6` (value 3) the counter takes 6 bits of weight 1 in `bits_in[5:0]`, no bits of weight 2, 4 bits of weight 4 in `[9:6]` and 1 bit of weight 8 in `[10]`. `sum_out` is 5 bits wide.
- R6: With `KIND = GPC_1_3_2_5` (value 4) the counter takes 5, 2, 3 and 1 bits of weight 1, 2, 4 and 8 in `bits_in[4:0]`, `[6:5]`, `[9:7]` and `[10]`. `sum_out` is 5 bits wide.
- R7: With `KIND = GPC_6_0_6` (value 5) the counter takes 6 bits of weight 1 in `bits_in[5:0]`, no bits of weight 2 and 6 bits of weight 4 in `[11:6]`. `sum_out` is 5 bits wide, and its largest value is 30.
- R8: `sum_out` never exceeds the largest weighted sum of the chosen shape: 7, 6, 31, 30, 29 and 30 for shapes 0 to 5. It never wraps.
- R9: Bit 0 of `sum_out` equals the XOR of the weight-1 input bits.
- R10: `sum_out` is zero exactly when every input bit is zero.
- R11: Inside one column, a bit's position has no effect. Only the number of set bits in each column counts, so the output is exact for every one of the 2^IN_W input patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bits_in | input | IN_W (6, 6, 11, 11, 11 or 12 by `KIND`) | Input bits packed column by column, lowest weight first |
| sum_out | output | OUT_W (3 or 5 by `KIND`) | Unsigned weighted sum of the set input bits |

## Verification
The two functions that fall in the same evaluation are the carry out of a full lower column and the count of the column above it. Both land in the same output bits, so a counter that mis-merges them only shows an error when both are loaded together. The bench provokes this with directed vectors that fill neighbouring columns at once, and with an exhaustive sweep of every input pattern of all six shapes. Each output is judged against a bit-by-bit weighted sum that the bench builds from its own table of column sizes.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

  localparam int MAX_COLS = 4;
  localparam int CNT_W    = 3;

  typedef enum logic [2:0] {
    GPC_1_5     = 3'd0,
    GPC_6       = 3'd1,
    GPC_1_4_1_5 = 3'd2,
    GPC_1_4_0_6 = 3'd3,
    GPC_1_3_2_5 = 3'd4,
    GPC_6_0_6   = 3'd5
  } gpc_kind_e;

  // number of input bits in column c (weight 2^c) for a shape
  function automatic int col_bits(gpc_kind_e k, int c);
    int r;
    r = 0;
    case (k)
      GPC_1_5:     case (c) 0: r = 5; 1: r = 1; default: r = 0; endcase
      GPC_6:       case (c) 0: r = 6; default: r = 0; endcase
      GPC_1_4_1_5: case (c) 0: r = 5; 1: r = 1; 2: r = 4; 3: r = 1; default: r = 0; endcase
      GPC_1_4_0_6: case (c) 0: r = 6; 2: r = 4; 3: r = 1; default: r = 0; endcase
      GPC_1_3_2_5: case (c) 0: r = 5; 1: r = 2; 2: r = 3; 3: r = 1; default: r = 0; endcase
      GPC_6_0_6:   case (c) 0: r = 6; 2: r = 6; default: r = 0; endcase
      default:     r = 0;
    endcase
    return r;
  endfunction

  // position of the first bit of column c in the packed input
  function automatic int col_offset(gpc_kind_e k, int c);
    int r;
    r = 0;
    for (int j = 0; j < c; j++) r += col_bits(k, j);
    return r;
  endfunction

  function automatic int in_width(gpc_kind_e k);
    return col_offset(k, MAX_COLS);
  endfunction

  // largest weighted sum: every input bit set
  function automatic int max_sum(gpc_kind_e k);
    int r;
    r = 0;
    for (int c = 0; c < MAX_COLS; c++) r += col_bits(k, c) << c;
    return r;
  endfunction

  function automatic int out_width(gpc_kind_e k);
    return $clog2(max_sum(k) + 1);
  endfunction

endpackage

// File: rtl/gpc_column.sv
module gpc_column #(
  parameter int N  = 5,
  parameter int CW = 3
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);

  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) count = count + CW'(bits[i]);
  end

  // R11: the column result is the number of set bits, whatever their position
  always_comb begin
    if (!$isunknown(bits)) begin
      assert_col_count_R11: assert (32'(count) == $countones(bits))
        else $error("column count mismatch");
    end
  end

endmodule

// File: rtl/gpc_weighted_add.sv
module gpc_weighted_add #(
  parameter int NCOL = 4,
  parameter int CW   = 3,
  parameter int OW   = 5
) (
  input  logic [NCOL-1:0][CW-1:0] cnt,
  output logic [OW-1:0]           total
);

  always_comb begin
    total = '0;
    for (int c = 0; c < NCOL; c++) total = total + (OW'(cnt[c]) << c);
  end

endmodule

// File: rtl/gpc_counter.sv
module gpc_counter #(
  parameter gpc_pkg::gpc_kind_e KIND = gpc_pkg::GPC_1_4_1_5,
  parameter int IN_W  = gpc_pkg::in_width(KIND),
  parameter int OUT_W = gpc_pkg::out_width(KIND)
) (
  input  logic [IN_W-1:0]  bits_in,
  output logic [OUT_W-1:0] sum_out
);
  import gpc_pkg::*;

  localparam int              COL0_W  = col_bits(KIND, 0);
  localparam logic [OUT_W-1:0] MAX_VAL = OUT_W'(max_sum(KIND));

  // per-column counts, brought out for the checks below
  logic [MAX_COLS-1:0][CNT_W-1:0] col_cnt;
  logic                           lsb_parity;
  logic                           all_zero;

  for (genvar c = 0; c < MAX_COLS; c++) begin : g_col
    if (col_bits(KIND, c) > 0) begin : g_used
      gpc_column #(
        .N  (col_bits(KIND, c)),
        .CW (CNT_W)
      ) u_col (
        .bits  (bits_in[col_offset(KIND, c) +: col_bits(KIND, c)]),
        .count (col_cnt[c])
      );
    end else begin : g_empty
      assign col_cnt[c] = '0;
    end
  end

  gpc_weighted_add #(
    .NCOL (MAX_COLS),
    .CW   (CNT_W),
    .OW   (OUT_W)
  ) u_add (
    .cnt   (col_cnt),
    .total (sum_out)
  );

  assign lsb_parity = ^bits_in[COL0_W-1:0];
  assign all_zero   = (bits_in == '0);

  always_comb begin
    if (!$isunknown(bits_in)) begin
      // R8: never above the shape's largest weighted sum
      assert_no_overflow_R8: assert (sum_out <= MAX_VAL)
        else $error("sum above shape maximum");
      // R9: weight-1 parity appears on the output LSB
      assert_lsb_parity_R9: assert (sum_out[0] == lsb_parity)
        else $error("output LSB differs from weight-1 parity");
      // R10: zero output only for an all-zero input
      assert_zero_iff_R10: assert (all_zero == (sum_out == '0))
        else $error("zero output mismatch");
      // R1: the port widths follow the chosen shape
      assert_shape_width_R1: assert (IN_W == in_width(KIND) && OUT_W == out_width(KIND))
        else $error("port width does not match shape");
    end
  end

endmodule

// File: tb/tb_gpc_counter.sv
module tb_gpc_counter;
  import gpc_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // column sizes per shape, weight 1 first (independent of the RTL package)
  localparam int COLS [6][4] = '{
    '{5, 1, 0, 0}, '{6, 0, 0, 0}, '{5, 1, 4, 1},
    '{6, 0, 4, 1}, '{5, 2, 3, 1}, '{6, 0, 6, 0}
  };
  localparam int IWS [6] = '{6, 6, 11, 11, 11, 12};
  localparam int OWS [6] = '{3, 3, 5, 5, 5, 5};

  // directed vectors: shape, input, expected
  localparam int NV = 16;
  localparam int VK [NV] = '{0, 0, 0, 1, 1, 2, 2, 2, 3, 3, 4, 4, 4, 5, 5, 5};
  localparam int VI [NV] = '{'h3F, 'h20, 'h1F, 'h3F, 'h01, 'h7FF, 'h400, 'h020,
                             'h7FF, 'h3C0, 'h7FF, 'h060, 'h380, 'hFFF, 'hFC0, 'h03F};
  localparam int VE [NV] = '{7, 2, 5, 6, 1, 31, 8, 2, 30, 16, 29, 4, 12, 30, 24, 6};

  logic [11:0] stim = '0;
  logic [2:0]  o0, o1;
  logic [4:0]  o2, o3, o4, o5;

  gpc_counter #(.KIND(GPC_1_5))     dut   (.bits_in(stim[5:0]),  .sum_out(o0));
  gpc_counter #(.KIND(GPC_6))       dut_1 (.bits_in(stim[5:0]),  .sum_out(o1));
  gpc_counter #(.KIND(GPC_1_4_1_5)) dut_2 (.bits_in(stim[10:0]), .sum_out(o2));
  gpc_counter #(.KIND(GPC_1_4_0_6)) dut_3 (.bits_in(stim[10:0]), .sum_out(o3));
  gpc_counter #(.KIND(GPC_1_3_2_5)) dut_4 (.bits_in(stim[10:0]), .sum_out(o4));
  gpc_counter #(.KIND(GPC_6_0_6))   dut_5 (.bits_in(stim[11:0]), .sum_out(o5));

  function automatic int out_of(int k);
    case (k)
      0: return int'(o0);
      1: return int'(o1);
      2: return int'(o2);
      3: return int'(o3);
      4: return int'(o4);
      default: return int'(o5);
    endcase
  endfunction

  function automatic int ref_sum(int k, int v);
    int s, pos;
    s = 0; pos = 0;
    for (int c = 0; c < 4; c++)
      for (int n = 0; n < COLS[k][c]; n++) begin
        if (((v >> pos) & 1) != 0) s += (1 << c);
        pos++;
      end
    return s;
  endfunction

  function automatic string shape_req(int k);
    case (k)
      0: return "R2"; 1: return "R3"; 2: return "R4";
      3: return "R5"; 4: return "R6"; default: return "R7";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic apply(int v);
    @(posedge clk);
    stim = 12'(v);
    @(negedge clk);
  endtask

  initial begin
    // R10: all-zero input state gives zero on every shape
    apply(0);
    for (int k = 0; k < 6; k++) chk("R10 zero input", out_of(k), 0);

    // R1 widths follow the shape
    chk("R1 width shape0", $bits(o0), OWS[0]);
    chk("R1 width shape5", $bits(o5), OWS[5]);

    // directed table: full and neighbouring-column patterns
    for (int i = 0; i < NV; i++) begin
      apply(VI[i]);
      chk({shape_req(VK[i]), " directed"}, out_of(VK[i]), VE[i]);
    end

    // R8: all ones reaches exactly the shape maximum
    apply('hFFF);
    for (int k = 0; k < 6; k++)
      chk("R8 maximum", out_of(k), ref_sum(k, (1 << IWS[k]) - 1));

    // R1/R11 exhaustive sweep of every shape, with R9 parity
    for (int v = 0; v < 4096; v++) begin
      apply(v);
      for (int k = 0; k < 6; k++)
        if (v < (1 << IWS[k])) begin
          chk({shape_req(k), " R1/R11 exhaustive"}, out_of(k), ref_sum(k, v));
          chk("R9 parity", out_of(k) & 1, ref_sum(k, v) & 1);
        end
    end

    // R10: single bit gives nonzero, back to zero gives zero
    apply('h800);
    chk("R10 top bit shape5", out_of(5), 4);
    apply(0);
    chk("R10 back to zero", out_of(5), 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule